// File: doc/BRIEF.md
# Sample Clock Divider with Duration Timer

This block produces the one-cycle sample-enable strobe that paces a logic analyzer's capture path. It runs from the core clock. Nominally that clock is 100 MHz, and software programs a divider maximum equal to the base rate divided by the wanted sample rate, minus one. A bypass bit skips division so that every core cycle is a sample. Bypass is used when the core runs at 125 MHz or is driven from an external sampling clock.

Alongside the strobe, the block keeps an elapsed-capture counter. The counter advances by one unit each time a fixed number of core cycles has passed, which is 100,000 by default. The cycle count per unit does not change with bypass. At 100 MHz a unit is therefore 1 ms, and at 125 MHz in bypass it is 0.8 ms. The counter holds at its maximum instead of wrapping. A synchronous start/clear input restarts both the divider and the duration counter at the beginning of a capture.

Top module: `sample_rate_gen`

## Requirements
- R1: With bypass low and divider maximum M > 0, call the first cycle after clear or reset cycle k = 0. Sample-enable is high exactly in the cycles where k mod (M+1) equals M, and it is low in all other cycles.
- R2: With bypass high, sample-enable is high in every cycle in which clear is low, whatever the divider maximum.
- R3: A divider maximum of zero with bypass low gives sample-enable high in every cycle in which clear is low.
- R4: While clear is high, sample-enable is low. The divider phase restarts so that the first cycle after clear is k = 0.
- R5: In cycle k after clear, the duration output equals floor(k / TICK_CYCLES), up to saturation.
- R6: The duration count advances at the same rate whether bypass is high or low.
- R7: The cycle after clear is high, the duration output is zero.
- R8: The duration output saturates at 2^DUR_W - 1 and holds there until cleared.
- R9: During reset the duration output is zero and the divider phase is zero. Sample-enable is therefore low for M > 0 with bypass low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Synchronous clear of divider and duration counter |
| div_max_i | input | DIV_W | Divider maximum (base rate / sample rate - 1) |
| bypass_i | input | 1 | Skip division, sample every cycle |
| sample_en_o | output | 1 | One-cycle sample strobe |
| duration_o | output | DUR_W | Elapsed-capture units, saturating |

## Verification
The bench sweeps every divider maximum of a small 4-bit configuration with bypass both off and on. A divider with an off-by-one wrap would shift the strobe to period M or M+2. The zero maximum is singled out, because a counter that compares with equality only after an increment would lose every other strobe there. Long runs with a 7-cycle unit and a 3-bit counter push the duration output into saturation, where a wrapping counter would fall back to zero. The same runs compare bypass on against bypass off, since a timer scaled by bypass would report a different count. Clear is applied after a run has progressed, so that a clear that missed either counter leaves a stale phase or a nonzero duration.

// File: rtl/smpclk_pkg.sv
package smpclk_pkg;

  // Width of a prescaler that counts 0 .. cycles-1; at least one bit.
  function automatic int unsigned prescale_width(input int unsigned cycles);
    return (cycles > 1) ? $clog2(cycles) : 1;
  endfunction

endpackage

// File: rtl/rate_divider.sv
module rate_divider #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             bypass_i,
  output logic             strobe_o
);

  logic [CNT_W-1:0] phase_q;
  logic [CNT_W-1:0] phase_d;
  logic             phase_en;
  logic             at_limit;

  assign at_limit = bypass_i || (phase_q >= limit_i);

  always_comb begin
    phase_en = 1'b1;
    if (clear_i || at_limit) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (phase_en) begin
      phase_q <= phase_d;
    end
  end

  assign strobe_o = !clear_i && at_limit;

endmodule

// File: rtl/unit_timer.sv
module unit_timer #(
  parameter int unsigned TICK_CYCLES = 100000,
  parameter int unsigned DUR_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  output logic [DUR_W-1:0] units_o
);
  import smpclk_pkg::*;

  localparam int unsigned PRE_W = prescale_width(TICK_CYCLES);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);
  localparam logic [DUR_W-1:0] UNITS_MAX = '1;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [DUR_W-1:0] units_q, units_d;
  logic             unit_done;
  logic             units_en;

  assign unit_done = (pre_q == PRE_LAST);

  always_comb begin
    if (clear_i || unit_done) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_comb begin
    units_en = clear_i || (unit_done && (units_q != UNITS_MAX));
    if (clear_i) begin
      units_d = '0;
    end else begin
      units_d = units_q + DUR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      units_q <= '0;
    end else if (units_en) begin
      units_q <= units_d;
    end
  end

  assign units_o = units_q;

endmodule

// File: rtl/sample_rate_gen.sv
module sample_rate_gen #(
  parameter int unsigned DIV_W       = 32,
  parameter int unsigned TICK_CYCLES = 100000,
  parameter int unsigned DUR_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] div_max_i,
  input  logic             bypass_i,
  output logic             sample_en_o,
  output logic [DUR_W-1:0] duration_o
);

  rate_divider #(
    .CNT_W(DIV_W)
  ) u_divider (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (start_i),
    .limit_i  (div_max_i),
    .bypass_i (bypass_i),
    .strobe_o (sample_en_o)
  );

  unit_timer #(
    .TICK_CYCLES(TICK_CYCLES),
    .DUR_W      (DUR_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start_i),
    .units_o (duration_o)
  );

endmodule

// File: rtl/sample_rate_gen_checker.sv
module sample_rate_gen_checker #(
  parameter int unsigned DIV_W = 32,
  parameter int unsigned DUR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [DIV_W-1:0] div_max_i,
  input logic             bypass_i,
  input logic             sample_en_o,
  input logic [DUR_W-1:0] duration_o
);
  localparam logic [DUR_W-1:0] DMAX = '1;

  a_r2_bypass_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_i && !start_i) |-> sample_en_o);

  a_r3_zero_max_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (div_max_i == '0 && !start_i) |-> sample_en_o);

  a_r4_no_sample_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !sample_en_o);

  a_r7_clear_zeroes_duration: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (duration_o == '0));

  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ((duration_o == $past(duration_o)) ||
                  (duration_o == $past(duration_o) + DUR_W'(1))));

  a_r8_saturate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && duration_o == DMAX) |=> (duration_o == DMAX));

endmodule

bind sample_rate_gen sample_rate_gen_checker #(
  .DIV_W(DIV_W),
  .DUR_W(DUR_W)
) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .div_max_i   (div_max_i),
  .bypass_i    (bypass_i),
  .sample_en_o (sample_en_o),
  .duration_o  (duration_o)
);

// File: tb/test_sample_rate_gen.sv
`timescale 1ns/1ps
module test_sample_rate_gen;
  localparam int DIV_W = 4;
  localparam int TICK  = 7;
  localparam int DUR_W = 3;
  localparam int DMAX  = (1 << DUR_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start_i;
  logic [DIV_W-1:0] div_max_i;
  logic             bypass_i;
  logic             sample_en_o;
  logic [DUR_W-1:0] duration_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sample_rate_gen #(
    .DIV_W(DIV_W), .TICK_CYCLES(TICK), .DUR_W(DUR_W)
  ) i_sample_rate_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .div_max_i(div_max_i),
    .bypass_i(bypass_i), .sample_en_o(sample_en_o), .duration_o(duration_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int exp_dur(input int k);
    return (k / TICK > DMAX) ? DMAX : k / TICK;
  endfunction

  // Pulse clear for one cycle; returns at cycle k = 0, sampled.
  task automatic do_clear();
    @(negedge clk);
    start_i = 1'b1;
    #1;
    chk("R4 strobe low during clear", int'(sample_en_o), 0);
    @(negedge clk);
    start_i = 1'b0;
    #1;
    chk("R7 duration zero after clear", int'(duration_o), 0);
  endtask

  // Run n cycles from k = 0 checking strobe and duration.
  task automatic run(input int m, input bit byp, input int n);
    for (int k = 0; k < n; k++) begin
      int e;
      e = (byp || m == 0 || (k % (m + 1)) == m) ? 1 : 0;
      if (byp)         chk("R2 bypass strobe", int'(sample_en_o), e);
      else if (m == 0) chk("R3 zero maximum strobe", int'(sample_en_o), e);
      else             chk("R1 divided strobe", int'(sample_en_o), e);
      if (exp_dur(k) == DMAX && k >= DMAX * TICK)
        chk("R8 saturated duration", int'(duration_o), DMAX);
      else if (byp)
        chk("R6 duration in bypass", int'(duration_o), exp_dur(k));
      else
        chk("R5 duration count", int'(duration_o), exp_dur(k));
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    #150000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    div_max_i = 4'd3;
    bypass_i = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset strobe", int'(sample_en_o), 0);
    chk("R9 reset duration", int'(duration_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // First cycle after reset release is k = 0 (reset phase zero).
    run(3, 1'b0, 9);

    // Sweep every divider maximum, bypass off and on.
    for (int m = 0; m < (1 << DIV_W); m++) begin
      for (int b = 0; b < 2; b++) begin
        div_max_i = DIV_W'(m);
        bypass_i  = b[0];
        do_clear();
        run(m, b[0], 3 * (m + 1) + 2);
      end
    end

    // Long runs into saturation, both bypass settings.
    for (int b = 0; b < 2; b++) begin
      div_max_i = 4'd2;
      bypass_i  = b[0];
      do_clear();
      run(2, b[0], TICK * (DMAX + 3));
      chk("R8 held at max", int'(duration_o), DMAX);
    end

    // Clear mid-run with nonzero duration and phase.
    div_max_i = 4'd4;
    bypass_i  = 1'b0;
    do_clear();
    run(4, 1'b0, 23);
    chk("R7 duration nonzero before clear", int'(duration_o != 0), 1);
    do_clear();
    run(4, 1'b0, 16);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule